// File: doc/BRIEF.md
# Aliased Merge Control Register

This block holds one 64-bit control word behind a small word-addressed register bus. Software can reach the word through three write addresses: one that replaces the contents outright, one that clears bits by ANDing the current contents with the written data, and one that sets bits by ORing them in. Only the sixteen most significant bits are kept. Every lower bit is discarded on every update, so the lower bits always read back as zero.

The most significant stored bit is presented as a level interrupt request towards an interrupt controller. Software raises or drops the request by writing that bit through any of the three addresses. Only the plain address returns the stored word on a read. Any access that the block does not implement produces a one-cycle notification pulse instead of a bus error. Each request carries a byte address, and the block divides it by eight to get the word offset. Only whole 64-bit words are transferred.

Top module: `aliased_ctl_reg`

## Requirements
- R1: After reset the stored word is zero, `irq_level` is 0, and `rsp_valid` and `unimpl_pulse` are 0.
- R2: A write accepted at word offset 0x4020 stores the written data with bits 47..0 forced to zero.
- R3: A write accepted at word offset 0x4021 stores the current word ANDed with the written data, with bits 47..0 zero.
- R4: A write accepted at word offset 0x4022 stores the current word ORed with the written data, with bits 47..0 zero.
- R5: Bits 47..0 of the stored word, and of every read response, are always zero.
- R6: `irq_level` equals bit 63 of the stored word. It changes on the same clock edge as the word.
- R7: A read accepted at any offset raises `rsp_valid` for the following cycle. A read at offset 0x4020 returns the word as it stood before that edge.
- R8: A read accepted at any offset other than 0x4020, the AND and OR offsets included, returns all zeros.
- R9: A write accepted at an offset other than 0x4020, 0x4021 or 0x4022 leaves the stored word and `irq_level` unchanged.
- R10: `unimpl_pulse` is high for exactly the cycle after an accepted access that is not implemented. That means a read at any offset other than 0x4020, or a write at any offset outside 0x4020..0x4022.
- R11: Writes accepted on consecutive cycles each act on the result of the previous write, with no update lost.
- R12: `req_ready` is always high, so every request is accepted in the cycle it is presented.
- R13: The word offset is the byte address shifted right by 3. Byte address bits 2..0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 64 | Read data |
| irq_level | output | 1 | Level interrupt request, stored bit 63 |
| unimpl_pulse | output | 1 | One-cycle pulse after an unimplemented access |

## Verification
The hardest case to bring about is a chain of AND and OR writes accepted on consecutive cycles, with a read issued in the very next cycle. A stale operand, or a read that does not return the word from before its own edge, shows up only there. The stimulus issues such chains back to back with no idle cycles, and follows a write that clears bit 63 through the AND alias with an OR write that sets it again. A long random phase then mixes all five offsets, including both neighbours of the implemented range, with random data and random low address bits. Every cycle is compared against the reference model.

// File: rtl/acr_pkg.sv
package acr_pkg;
  // Kind of update selected by the address decoder
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_AND  = 2'd2,
    OP_OR   = 2'd3
  } wr_op_e;

  // Word slot a request lands on
  typedef enum logic [1:0] {
    SLOT_PLAIN = 2'd0,
    SLOT_CLR   = 2'd1,
    SLOT_SET   = 2'd2,
    SLOT_OTHER = 2'd3
  } slot_e;
endpackage

// File: rtl/acr_decode.sv
module acr_decode
  import acr_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int WORD_SHIFT = 3,
  parameter int BASE_WORD  = 'h4020
) (
  input  logic              acc,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_op_e            op,
  output logic              rd_go,
  output logic              rd_hit,
  output logic              bad
);
  localparam int OFF_W = ADDR_W - WORD_SHIFT;
  localparam logic [OFF_W-1:0] W_PLAIN = OFF_W'(BASE_WORD);
  localparam logic [OFF_W-1:0] W_CLR   = OFF_W'(BASE_WORD + 1);
  localparam logic [OFF_W-1:0] W_SET   = OFF_W'(BASE_WORD + 2);

  function automatic slot_e slot_of(input logic [OFF_W-1:0] w);
    if (w == W_PLAIN)    return SLOT_PLAIN;
    else if (w == W_CLR) return SLOT_CLR;
    else if (w == W_SET) return SLOT_SET;
    else                 return SLOT_OTHER;
  endfunction

  logic [OFF_W-1:0]      word;
  logic [WORD_SHIFT-1:0] unused_byte_lane;
  slot_e                 slot;

  assign word             = addr[ADDR_W-1:WORD_SHIFT];
  assign unused_byte_lane = addr[WORD_SHIFT-1:0];
  assign slot             = slot_of(word);

  always_comb begin
    op = OP_NONE;
    if (acc && wr) begin
      unique case (slot)
        SLOT_PLAIN: op = OP_LOAD;
        SLOT_CLR:   op = OP_AND;
        SLOT_SET:   op = OP_OR;
        default:    op = OP_NONE;
      endcase
    end
  end

  assign rd_go  = acc && !wr;
  assign rd_hit = rd_go && (slot == SLOT_PLAIN);
  assign bad    = acc && (wr ? (slot == SLOT_OTHER) : (slot != SLOT_PLAIN));
endmodule

// File: rtl/acr_merge.sv
module acr_merge
  import acr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input  wr_op_e            op,
  input  logic [KEEP_W-1:0] cur_keep,
  input  logic [DATA_W-1:0] wdata,
  output logic [KEEP_W-1:0] nxt_keep,
  output logic              upd
);
  localparam int LO_W = DATA_W - KEEP_W;

  function automatic logic [KEEP_W-1:0] merge_bits(
    input wr_op_e            o,
    input logic [KEEP_W-1:0] cur,
    input logic [KEEP_W-1:0] d
  );
    case (o)
      OP_LOAD: return d;
      OP_AND:  return cur & d;
      OP_OR:   return cur | d;
      default: return cur;
    endcase
  endfunction

  logic [KEEP_W-1:0] wd_keep;
  assign wd_keep = wdata[DATA_W-1:LO_W];

  generate
    if (LO_W > 0) begin : g_lo_sink
      logic [LO_W-1:0] unused_low_data;
      assign unused_low_data = wdata[LO_W-1:0];
    end
  endgenerate

  assign nxt_keep = merge_bits(op, cur_keep, wd_keep);
  assign upd      = (op != OP_NONE);
endmodule

// File: rtl/acr_store.sv
module acr_store #(
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [KEEP_W-1:0] nxt_keep,
  output logic [KEEP_W-1:0] keep_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd) begin
      keep_q <= nxt_keep;
      irq_q  <= nxt_keep[KEEP_W-1];
    end
  end
endmodule

// File: rtl/acr_resp.sv
module acr_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic              rd_hit,
  input  logic              bad,
  input  logic [DATA_W-1:0] cur_full,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              unimpl_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      unimpl_pulse <= 1'b0;
    end else begin
      rsp_valid    <= rd_go;
      rsp_rdata    <= rd_hit ? cur_full : '0;
      unimpl_pulse <= bad;
    end
  end
endmodule

// File: rtl/aliased_ctl_reg.sv
module aliased_ctl_reg
  import acr_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int KEEP_W     = 16,
  parameter int ADDR_W     = 24,
  parameter int WORD_SHIFT = 3,
  parameter int BASE_WORD  = 'h4020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_level,
  output logic              unimpl_pulse
);
  localparam int LO_W = DATA_W - KEEP_W;

  // Named internal events, visible to the bound checker
  logic              acc;
  wr_op_e            wr_op;
  logic              rd_go;
  logic              rd_hit;
  logic              bad;
  logic              upd;
  logic [KEEP_W-1:0] nxt_keep;
  logic [KEEP_W-1:0] keep_q;
  logic [DATA_W-1:0] reg_full;

  assign req_ready = 1'b1;
  assign acc       = req_valid && req_ready;

  acr_decode #(
    .ADDR_W(ADDR_W), .WORD_SHIFT(WORD_SHIFT), .BASE_WORD(BASE_WORD)
  ) u_decode (
    .acc(acc), .wr(req_write), .addr(req_addr),
    .op(wr_op), .rd_go(rd_go), .rd_hit(rd_hit), .bad(bad)
  );

  acr_merge #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_merge (
    .op(wr_op), .cur_keep(keep_q), .wdata(req_wdata),
    .nxt_keep(nxt_keep), .upd(upd)
  );

  acr_store #(.KEEP_W(KEEP_W)) u_store (
    .clk(clk), .rst_n(rst_n), .upd(upd), .nxt_keep(nxt_keep),
    .keep_q(keep_q), .irq_q(irq_level)
  );

  generate
    if (LO_W > 0) begin : g_pad
      assign reg_full = {keep_q, {LO_W{1'b0}}};
    end else begin : g_nopad
      assign reg_full = keep_q;
    end
  endgenerate

  acr_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_hit(rd_hit), .bad(bad),
    .cur_full(reg_full), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .unimpl_pulse(unimpl_pulse)
  );
endmodule

// File: rtl/acr_checker.sv
module acr_checker
  import acr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int KEEP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input wr_op_e            wr_op,
  input logic              rd_go,
  input logic              rd_hit,
  input logic              bad,
  input logic [DATA_W-1:0] reg_full,
  input logic              irq_level,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              unimpl_pulse
);
  localparam logic [DATA_W-1:0] HI_MASK = {{KEEP_W{1'b1}}, {(DATA_W-KEEP_W){1'b0}}};

  AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_LOAD) |=> reg_full == ($past(req_wdata) & HI_MASK)); // R2
  AST_AND_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_AND) |=> reg_full == ($past(reg_full) & $past(req_wdata) & HI_MASK)); // R3
  AST_OR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == OP_OR) |=> reg_full == (($past(reg_full) | $past(req_wdata)) & HI_MASK)); // R4
  AST_IRQ_FOLLOWS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == reg_full[DATA_W-1]); // R6
  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(rd_go)); // R7
  AST_RSP_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rsp_rdata == $past(reg_full)); // R7
  AST_RSP_ZERO_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !rd_hit) |=> rsp_rdata == '0); // R8
  AST_BAD_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && req_write) |=> ($stable(reg_full) && $stable(irq_level))); // R9
  AST_UNIMPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_pulse == $past(bad)); // R10
endmodule

bind aliased_ctl_reg acr_checker #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_acr_checker (
  .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_wdata(req_wdata),
  .wr_op(wr_op), .rd_go(rd_go), .rd_hit(rd_hit), .bad(bad),
  .reg_full(reg_full), .irq_level(irq_level), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .unimpl_pulse(unimpl_pulse)
);

// File: tb/test_aliased_ctl_reg.sv
module test_aliased_ctl_reg;
  localparam int PLAIN = 'h4020;
  localparam logic [63:0] HI = 64'hFFFF_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_level, unimpl_pulse;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  aliased_ctl_reg i_aliased_ctl_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_level(irq_level),
    .unimpl_pulse(unimpl_pulse)
  );

  // Behavioural reference model
  logic [63:0] m_reg = '0;
  logic        m_rv = 1'b0, m_un = 1'b0, m_hit = 1'b0;
  logic [63:0] m_rd = '0;
  string       m_wtag = "R1";

  always @(posedge clk) begin
    int w;
    logic [63:0] nv;
    w  = int'(req_addr) / 8;  // R13: byte address divided by eight
    nv = m_reg;
    if (!rst_n) begin
      m_reg <= '0; m_rv <= 0; m_rd <= '0; m_un <= 0; m_hit <= 0; m_wtag <= "R1";
    end else begin
      m_rv  <= req_valid && !req_write;
      m_hit <= req_valid && !req_write && w == PLAIN;
      m_rd  <= (req_valid && !req_write && w == PLAIN) ? m_reg : 64'd0;
      m_un  <= req_valid && (req_write ? (w < PLAIN || w > PLAIN + 2) : w != PLAIN);
      if (req_valid && req_write) begin
        if (w == PLAIN)          begin nv = req_wdata;         m_wtag <= "R2"; end
        else if (w == PLAIN + 1) begin nv = m_reg & req_wdata; m_wtag <= "R3"; end
        else if (w == PLAIN + 2) begin nv = m_reg | req_wdata; m_wtag <= "R4"; end
        m_reg <= nv & HI;  // R5 mask
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(irq_level == 0 && rsp_valid == 0 && unimpl_pulse == 0, "R1 reset outputs",
          {61'd0, irq_level, rsp_valid, unimpl_pulse}, 64'd0);
    end else begin
      chk(req_ready == 1'b1, "R12 ready", {63'd0, req_ready}, 64'd1);
      chk(irq_level == m_reg[63], "R6 irq level", {63'd0, irq_level}, {63'd0, m_reg[63]});
      chk(rsp_valid == m_rv, "R7 rsp_valid", {63'd0, rsp_valid}, {63'd0, m_rv});
      chk(unimpl_pulse == m_un, "R10 unimpl_pulse", {63'd0, unimpl_pulse}, {63'd0, m_un});
      if (m_rv)
        chk(rsp_rdata == m_rd, m_hit ? {"R7 read data after ", m_wtag} : "R8 zero read",
            rsp_rdata, m_rd);
      if (rsp_valid)
        chk(rsp_rdata[47:0] == 48'd0, "R5 low bits", rsp_rdata, rsp_rdata & HI);
    end
  end

  task automatic acc(input bit wr, input int word, input logic [63:0] d, input logic [2:0] lo = 3'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_addr  = 24'(word * 8) | {21'd0, lo};
    req_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    acc(0, PLAIN, 0);                              // R1 zero after reset
    acc(1, PLAIN, 64'hFFFF_FFFF_FFFF_FFFF);       // R2 R5
    acc(0, PLAIN, 0);
    acc(1, PLAIN + 1, 64'h7FFF_FFFF_FFFF_FFFF);   // R3 drops irq (R6)
    acc(0, PLAIN, 0);
    acc(1, PLAIN + 2, 64'h8000_0000_0000_1234);   // R4 raises irq
    acc(0, PLAIN, 0);
    idle(2);
    // R11: back-to-back chain then immediate read
    acc(1, PLAIN, 64'h1234_5678_9ABC_DEF0);
    acc(1, PLAIN + 1, 64'hFF00_0000_0000_0000);
    acc(1, PLAIN + 2, 64'h8001_0000_0000_0000);
    acc(1, PLAIN + 1, 64'h00FF_FFFF_FFFF_FFFF);
    acc(0, PLAIN, 0);
    acc(1, PLAIN + 2, 64'hC000_0000_0000_0000);
    acc(0, PLAIN, 0);
    // R8 R10: alias and foreign reads
    acc(0, PLAIN + 1, 0);
    acc(0, PLAIN + 2, 0);
    acc(0, PLAIN + 3, 0);
    acc(0, PLAIN - 1, 0);
    // R9: foreign writes leave state alone
    acc(1, PLAIN + 3, 64'h0);
    acc(1, PLAIN - 1, 64'h0);
    acc(0, PLAIN, 0);
    // R13: low byte-address bits ignored
    acc(1, PLAIN, 64'hA5A5_0000_0000_0000, 3'd5);
    acc(0, PLAIN, 0, 3'd7);
    idle(1);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) idle(1);
      acc(1'($urandom_range(0, 1)), PLAIN - 1 + int'($urandom_range(0, 4)),
          {$urandom, $urandom}, 3'($urandom_range(0, 7)));
    end
    acc(0, PLAIN, 0);
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule